// File: doc/BRIEF.md
# Powered-Device Inrush and Power-Good Sequencer

This block decides when a powered device on a cable-fed supply connects its load and when it lets the downstream converter run. It watches a pair of undervoltage comparator outputs, a flag saying the isolation switch is fully enhanced, a flag saying the return node is above the foldback level, and a thermal flag whose hysteresis is applied by the comparator. From these it drives the switch enable, the selection between the low inrush current limit and the higher running limit, a foldback request, an active-low hold that keeps the converter disabled, and a permission line for the LED driver and the indication sink.

Power-up goes through an inrush phase in which the low limit is used and the converter is held off. The hold is released only after a fixed minimum time has elapsed and the switch has reported full enhancement, whichever comes later. A dip below the turn-off threshold must persist for longer than a deglitch window before the switch is dropped. A thermal trip opens the switch, and cooling sends the block back through a full inrush phase. A sleep request pulls the hold low while the switch stays closed. Both timers are measured in clock cycles, and their lengths are parameters.

Top module: `pd_power_seq`

## Requirements
- R1: While reset is asserted, the outputs are sw_en=0, ilim_normal=0, fold_req=0, pg_hold_n=1 and aux_allow=0.
- R2: From the off state, vin_above_on high with temp_hot low enters inrush one cycle later. In inrush, sw_en=1, ilim_normal=0, pg_hold_n=0 and aux_allow=1.
- R3: During inrush, ilim_normal rises one cycle after sw_full_on is sampled high. Once raised, it stays high until the switch is next disabled.
- R4: pg_hold_n stays low for HOLD_CYC+1 cycles after sw_en rises. It also stays low until sw_full_on has been seen. It rises in the cycle after both conditions hold.
- R5: vin_below_off must be high for DEGLITCH_CYC+1 consecutive cycles to cause turn-off. At turn-off, sw_en=0, ilim_normal=0, aux_allow=0 and pg_hold_n=1. A dip of DEGLITCH_CYC cycles or fewer is ignored, and any cycle with vin_below_off low restarts the count.
- R6: temp_hot sampled high in inrush or power mode gives sw_en=0, aux_allow=0, ilim_normal=0 and pg_hold_n=0 on the next cycle. These values hold while temp_hot stays high.
- R7: When temp_hot falls during thermal shutdown, the block re-enters inrush with the low limit and pg_hold_n low. It then repeats the full hold time.
- R8: In power mode, sleep_req drives pg_hold_n low in the same cycle without changing sw_en or ilim_normal. In the off state, sleep_req leaves pg_hold_n high.
- R9: fold_req follows rtn_over_fold only in power mode. It is 0 in the off, inrush and thermal states.
- R10: In the off state, the switch stays off while vin_above_on is low. It also stays off while temp_hot is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_above_on | input | 1 | Input voltage above the turn-on threshold |
| vin_below_off | input | 1 | Input voltage below the turn-off threshold |
| sw_full_on | input | 1 | Isolation switch fully enhanced |
| rtn_over_fold | input | 1 | Return voltage above the foldback threshold |
| temp_hot | input | 1 | Junction over-temperature (hysteresis applied by the comparator) |
| sleep_req | input | 1 | Sleep mode request |
| sw_en | output | 1 | Isolation switch enable |
| ilim_normal | output | 1 | 1 selects the running current limit, 0 selects the inrush limit |
| fold_req | output | 1 | Current-limit foldback request |
| pg_hold_n | output | 1 | Active-low hold: 0 keeps the downstream converter disabled |
| aux_allow | output | 1 | Permission for the LED driver and the indication sink |

## Verification
The bench targets three kinds of internal fault.

- **Hold counter.** A counter that starts late, or that is not cleared on re-entry, makes pg_hold_n rise one or more cycles earlier or later than HOLD_CYC+1 cycles after sw_en. The bench pins this edge to the exact cycle, both after a cold start and after thermal recovery.
- **Deglitch counter.** A counter that fails to restart drops sw_en during a dip of exactly the window length. A counter that restarts too eagerly keeps sw_en high one cycle past DEGLITCH_CYC+1.
- **State register.** A wrong state shows within one cycle as an illegal output combination, such as the normal limit while the converter is held in inrush, or foldback outside power mode.

// File: rtl/pd_seq_pkg.sv
`timescale 1ns/1ps
package pd_seq_pkg;

   typedef enum logic [1:0] {
      PS_OFF     = 2'd0,
      PS_INRUSH  = 2'd1,
      PS_POWER   = 2'd2,
      PS_THERMAL = 2'd3
   } pseq_state_e;

   typedef struct packed {
      logic above_on;
      logic below_off;
      logic enhanced;
      logic rtn_high;
      logic hot;
      logic sleep;
   } pseq_in_t;

   localparam int unsigned PSEQ_IN_W = 6;

endpackage

// File: rtl/pd_seq_timer.sv
`timescale 1ns/1ps
// Saturating run-length timer: done is high once run has held for LIMIT edges.
module pd_seq_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT == 1) begin : g_single
         logic seen;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   seen <= 1'b0;
            else          seen <= run;
         end
         assign done = seen;
      end else begin : g_count
         localparam logic [CW-1:0] LIM_V = CW'(LIMIT);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!run)          cnt <= '0;
            else if (cnt != LIM_V)  cnt <= cnt + 1'b1;
         end
         assign done = (cnt == LIM_V);
      end
   endgenerate

endmodule

// File: rtl/pd_seq_fsm.sv
`timescale 1ns/1ps
module pd_seq_fsm
   import pd_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  pseq_in_t    in_s,
   input  logic        dg_done,
   input  logic        hold_done,
   output pseq_state_e state,
   output logic        enh_seen
);
   pseq_state_e nxt;
   logic        drop;

   // Turn-off needs the window spent and the input still low on this edge.
   assign drop = dg_done & in_s.below_off;

   always_comb begin
      nxt = state;
      unique case (state)
         PS_OFF: begin
            if (in_s.above_on && !in_s.hot) nxt = PS_INRUSH;
         end
         PS_INRUSH: begin
            if (drop)                         nxt = PS_OFF;
            else if (in_s.hot)                nxt = PS_THERMAL;
            else if (hold_done && enh_seen)   nxt = PS_POWER;
         end
         PS_POWER: begin
            if (drop)                         nxt = PS_OFF;
            else if (in_s.hot)                nxt = PS_THERMAL;
         end
         PS_THERMAL: begin
            if (drop)                         nxt = PS_OFF;
            else if (!in_s.hot)               nxt = PS_INRUSH;
         end
         default: nxt = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PS_OFF;
         enh_seen <= 1'b0;
      end else begin
         state    <= nxt;
         if (state == PS_INRUSH && nxt == PS_INRUSH)
            enh_seen <= enh_seen | in_s.enhanced;
         else
            enh_seen <= 1'b0;
      end
   end

endmodule

// File: rtl/pd_seq_outdec.sv
`timescale 1ns/1ps
module pd_seq_outdec
   import pd_seq_pkg::*;
(
   input  pseq_state_e state,
   input  logic        enh_seen,
   input  pseq_in_t    in_s,
   output logic        sw_en,
   output logic        ilim_normal,
   output logic        fold_req,
   output logic        pg_hold_n,
   output logic        aux_allow
);
   logic in_inrush, in_power, in_thermal;

   assign in_inrush  = (state == PS_INRUSH);
   assign in_power   = (state == PS_POWER);
   assign in_thermal = (state == PS_THERMAL);

   always_comb begin
      sw_en       = in_inrush | in_power;
      aux_allow   = in_inrush | in_power;
      ilim_normal = in_power | (in_inrush & enh_seen);
      fold_req    = in_power & in_s.rtn_high;
      pg_hold_n   = ~(in_inrush | in_thermal | (in_power & in_s.sleep));
   end

endmodule

// File: rtl/pd_power_seq.sv
`timescale 1ns/1ps
module pd_power_seq
   import pd_seq_pkg::*;
#(
   parameter int unsigned DEGLITCH_CYC = 12000,
   parameter int unsigned HOLD_CYC     = 19200000,
   parameter int unsigned SYNC_STAGES  = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vin_above_on,
   input  logic vin_below_off,
   input  logic sw_full_on,
   input  logic rtn_over_fold,
   input  logic temp_hot,
   input  logic sleep_req,
   output logic sw_en,
   output logic ilim_normal,
   output logic fold_req,
   output logic pg_hold_n,
   output logic aux_allow
);
   if (DEGLITCH_CYC < 1) begin : g_bad_dg
      $error("pd_power_seq: DEGLITCH_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("pd_power_seq: HOLD_CYC must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("pd_power_seq: SYNC_STAGES must be 4 or less");
   end

   pseq_in_t    raw_in, syn_in;
   pseq_state_e state;
   logic        enh_seen, dg_done, hold_done;

   assign raw_in = '{above_on:  vin_above_on,
                     below_off: vin_below_off,
                     enhanced:  sw_full_on,
                     rtn_high:  rtn_over_fold,
                     hot:       temp_hot,
                     sleep:     sleep_req};

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn_in = raw_in;
      end else begin : g_sync
         logic [PSEQ_IN_W-1:0] pipe [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(SYNC_STAGES); i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= raw_in;
               for (int i = 1; i < int'(SYNC_STAGES); i++) pipe[i] <= pipe[i-1];
            end
         end
         assign syn_in = pseq_in_t'(pipe[SYNC_STAGES-1]);
      end
   endgenerate

   pd_seq_timer #(.LIMIT(DEGLITCH_CYC)) u_dg_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (syn_in.below_off && (state != PS_OFF)),
      .done  (dg_done)
   );

   pd_seq_timer #(.LIMIT(HOLD_CYC)) u_hold_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == PS_INRUSH),
      .done  (hold_done)
   );

   pd_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_s      (syn_in),
      .dg_done   (dg_done),
      .hold_done (hold_done),
      .state     (state),
      .enh_seen  (enh_seen)
   );

   pd_seq_outdec u_outdec (
      .state       (state),
      .enh_seen    (enh_seen),
      .in_s        (syn_in),
      .sw_en       (sw_en),
      .ilim_normal (ilim_normal),
      .fold_req    (fold_req),
      .pg_hold_n   (pg_hold_n),
      .aux_allow   (aux_allow)
   );

endmodule

// File: rtl/pd_power_seq_chk.sv
`timescale 1ns/1ps
module pd_power_seq_chk #(
   parameter int unsigned HOLD_CYC = 16
) (
   input logic clk,
   input logic rst_n,
   input logic sw_en,
   input logic ilim_normal,
   input logic fold_req,
   input logic pg_hold_n,
   input logic aux_allow
);
   localparam int unsigned HW = $clog2(HOLD_CYC + 2);
   localparam logic [HW-1:0] HOLD_V = HW'(HOLD_CYC);

   logic [HW-1:0] on_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               on_cnt <= '0;
      else if (!sw_en)          on_cnt <= '0;
      else if (on_cnt < HOLD_V) on_cnt <= on_cnt + 1'b1;
   end

   // R4: converter stays held for the minimum window after the switch closes
   p_hold_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && on_cnt < HOLD_V) |-> !pg_hold_n);

   // R2: each switch-on starts on the inrush limit with the converter held
   p_entry_inrush_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en) |-> (!ilim_normal && !pg_hold_n));

   // R3: the running limit never reverts to inrush while the switch stays on
   p_lim_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && ilim_normal) |=> (!sw_en || ilim_normal));

   // R4: release of the hold with the switch on implies the normal limit
   p_release_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pg_hold_n) && sw_en) |-> ilim_normal);

   // R9: foldback only with the switch on and the running limit
   p_fold_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fold_req |-> (sw_en && ilim_normal && aux_allow));

   // R2: inrush limit never coexists with a released hold
   p_inrush_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && !ilim_normal) |-> !pg_hold_n);

endmodule

bind pd_power_seq pd_power_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_en       (sw_en),
   .ilim_normal (ilim_normal),
   .fold_req    (fold_req),
   .pg_hold_n   (pg_hold_n),
   .aux_allow   (aux_allow)
);

// File: tb/pd_power_seq_bench.sv
`timescale 1ns/1ps
module pd_power_seq_bench;

   localparam int unsigned DG   = 8;
   localparam int unsigned HOLD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic above_on = 1'b0, below_off = 1'b1, full_on = 1'b0;
   logic rtn_hi = 1'b0, hot = 1'b0, slp = 1'b0;
   logic sw_en, ilim_normal, fold_req, pg_hold_n, aux_allow;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pd_power_seq #(.DEGLITCH_CYC(DG), .HOLD_CYC(HOLD), .SYNC_STAGES(0)) u_pd_power_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .vin_above_on  (above_on),
      .vin_below_off (below_off),
      .sw_full_on    (full_on),
      .rtn_over_fold (rtn_hi),
      .temp_hot      (hot),
      .sleep_req     (slp),
      .sw_en         (sw_en),
      .ilim_normal   (ilim_normal),
      .fold_req      (fold_req),
      .pg_hold_n     (pg_hold_n),
      .aux_allow     (aux_allow)
   );

   // stim: {above_on, below_off, full_on, rtn_hi, hot, slp}
   // exp : {sw_en, ilim_normal, fold_req, pg_hold_n, aux_allow}
   typedef struct packed {
      logic [5:0] stim;
      logic [7:0] n;
      logic [4:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{6'b010000, 8'd3,  5'b00010, 4'd10}, // R10 off, no turn-on request
      '{6'b010001, 8'd2,  5'b00010, 4'd8},  // R8 sleep in off leaves hold high
      '{6'b100000, 8'd1,  5'b10001, 4'd2},  // R2 enter inrush
      '{6'b100100, 8'd5,  5'b10001, 4'd9},  // R9 no foldback during inrush
      '{6'b101000, 8'd1,  5'b11001, 4'd3},  // R3 normal limit after enhanced
      '{6'b101000, 8'd13, 5'b11001, 4'd4},  // R4 still held (19 edges)
      '{6'b101000, 8'd1,  5'b11001, 4'd4},  // R4 still held (20 edges)
      '{6'b101000, 8'd1,  5'b11011, 4'd4},  // R4 released at edge 21
      '{6'b101100, 8'd1,  5'b11111, 4'd9},  // R9 foldback in power mode
      '{6'b101001, 8'd1,  5'b11001, 4'd8},  // R8 sleep pulls hold low
      '{6'b101000, 8'd1,  5'b11011, 4'd8},  // R8 sleep released
      '{6'b001000, 8'd4,  5'b11011, 4'd5},  // R5 between thresholds: stays on
      '{6'b011000, 8'd8,  5'b11011, 4'd5},  // R5 dip of DG cycles ignored
      '{6'b001000, 8'd1,  5'b11011, 4'd5},  // R5 recover, count restarts
      '{6'b011000, 8'd8,  5'b11011, 4'd5},  // R5 second DG dip ignored
      '{6'b011000, 8'd1,  5'b00010, 4'd5},  // R5 DG+1 cycles: off
      '{6'b101010, 8'd3,  5'b00010, 4'd10}, // R10 hot blocks turn-on
      '{6'b101000, 8'd1,  5'b10001, 4'd2},  // R2 enter inrush on the inrush limit
      '{6'b101000, 8'd1,  5'b11001, 4'd3},  // R3 limit switches
      '{6'b101000, 8'd25, 5'b11011, 4'd4},  // R4 in power mode
      '{6'b101010, 8'd1,  5'b00000, 4'd6},  // R6 thermal trip
      '{6'b101010, 8'd4,  5'b00000, 4'd6},  // R6 stays off while hot
      '{6'b101000, 8'd1,  5'b10001, 4'd7},  // R7 cool: back to inrush
      '{6'b101000, 8'd1,  5'b11001, 4'd7},  // R7 limit again after enhanced
      '{6'b101000, 8'd19, 5'b11001, 4'd7},  // R7 full hold repeated
      '{6'b101000, 8'd1,  5'b11011, 4'd7},  // R7 released at edge 21
      '{6'b011010, 8'd1,  5'b00000, 4'd6},  // R6 trip while input low
      '{6'b011010, 8'd8,  5'b00010, 4'd5}   // R5 deglitch expires in thermal
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input logic [4:0] exp, input int req, input string what);
      logic [4:0] act;
      act = {sw_en, ilim_normal, fold_req, pg_hold_n, aux_allow};
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
      end
   endtask

   initial begin : main
      tick(3);
      check(5'b00010, 1, "R1 outputs in reset");
      rst_n = 1'b1;
      tick(1);

      for (int i = 0; i < NV; i++) begin
         {above_on, below_off, full_on, rtn_hi, hot, slp} = VECS[i].stim;
         tick(int'(VECS[i].n));
         check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
      end

      // R4: late enhancement keeps the hold past the minimum time
      {above_on, below_off, full_on, rtn_hi, hot, slp} = 6'b100000;
      tick(1);
      check(5'b10001, 2, "R2 re-entry from off");
      tick(30);
      check(5'b10001, 4, "R4 held while not enhanced");
      full_on = 1'b1;
      tick(1);
      check(5'b11001, 3, "R3 limit after late enhance");
      tick(1);
      check(5'b11011, 4, "R4 released after late enhance");

      // R1: reset in power mode
      rst_n = 1'b0;
      tick(1);
      check(5'b00010, 1, "R1 mid-run reset");
      rst_n = 1'b1;
      tick(1);
      check(5'b10001, 2, "R2 entry after reset");

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule